// File: doc/BRIEF.md
# Masked Circular Address Generator

This block produces the final operand address for a multiply-accumulate datapath. An earlier stage computes a 32-bit effective address. When masking applies to the access, the block ANDs that address with a wide mask. The low half of the mask comes from a programmable 16-bit register and the high half is fixed at ones. Clearing mask bits confines the address to a region, so that a buffer walked with post-increment addressing wraps around without any bound comparison.

The mask register is loaded and read back over a 32-bit port. It keeps only the low half of a write. On reads, it returns ones in the high half.

Masking applies to an access when its enable is set. It also applies when the access is a combined multiply-accumulate-and-move and the global "mask all moves" option is on. For post-increment, the block also returns the updated pointer. That pointer is the address plus the operand size, passed through the same mask so that it wraps inside the region.

Top module: `mac_addr_gen`

## Requirements
- R1: After reset, the mask register holds 16'hFFFF, so `mask_rdata_o` reads 32'hFFFF_FFFF.
- R2: When `mask_we_i` is high at a rising clock edge, the mask register takes `mask_wdata_i[15:0]`. The upper half of the written value is discarded, and the new value is seen from the cycle after the edge.
- R3: `mask_rdata_o[31:16]` is always 16'hFFFF and `mask_rdata_o[15:0]` is the stored mask.
- R4: When masking applies, `addr_o` equals `ea_i & {16'hFFFF, mask}`.
- R5: When masking does not apply, `addr_o` equals `ea_i` unchanged.
- R6: Masking applies when `mask_en_i` is 1, or when both `mac_move_i` and `mask_all_i` are 1. `mask_all_i` with `mac_move_i` at 0 has no effect.
- R7: With `post_inc_i` at 1, `ptr_next_o` is `ea_i + inc`, masked under the same rule as the address. The increment `inc` is 2 when `size_sel_i` is 0 and 4 when `size_sel_i` is 1.
- R8: With `post_inc_i` at 0, `ptr_next_o` equals `ea_i`.
- R9: A pointer stepping past the top of a masked region wraps to the region base. For example, mask 16'h00FF, address 32'h2000_00FC, size 4 gives 32'h2000_0000.
- R10: With `mask_we_i` low at an edge, the mask register keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mask_we_i | input | 1 | Mask register write strobe |
| mask_wdata_i | input | 32 | Mask register write data (low 16 bits kept) |
| mask_rdata_o | output | 32 | Mask register read data, upper half ones |
| ea_i | input | 32 | Computed effective address |
| mask_en_i | input | 1 | Per-access mask enable |
| mac_move_i | input | 1 | Access belongs to a combined multiply-accumulate-and-move operation |
| mask_all_i | input | 1 | Apply mask to every combined-move access |
| post_inc_i | input | 1 | Access uses post-increment |
| size_sel_i | input | 1 | Operand size: 0 = 2 bytes, 1 = 4 bytes |
| addr_o | output | 32 | Final operand address |
| ptr_next_o | output | 32 | Updated address-register value |

## Verification
The bench checks the pointer at the top of a masked region with both operand sizes. A design that masked before adding, or that never masked the pointer, would step out of the buffer instead of wrapping to the base.

It writes the mask with nonzero upper data. A design that stored the full word, or that read back zeros in the upper half, would then return a wrong read value. The same design would also corrupt the upper address bits.

It drives `mask_all_i` without `mac_move_i`, and `mac_move_i` without `mask_all_i`. A design with a wrong enable term would then mask accesses it should pass through.

Random write strobes, some held low, show whether a design updates the mask without a write or applies a new mask in the same cycle as the write.

// File: rtl/mag_pkg.sv
package mag_pkg;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned MASK_W = 16;

  typedef enum logic {
    SZ_WORD = 1'b0,
    SZ_LONG = 1'b1
  } op_size_e;
endpackage

// File: rtl/mag_mask_reg.sv
module mag_mask_reg #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned MASK_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] wdata_i,
  output logic [MASK_W-1:0] mask_o,
  output logic [ADDR_W-1:0] rdata_o
);
  localparam int unsigned HI_W = ADDR_W - MASK_W;

  logic [MASK_W-1:0] mask_q;
  logic              unused_wdata_hi;

  assign unused_wdata_hi = ^wdata_i[ADDR_W-1:MASK_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mask_q <= '1;
    else if (we_i) mask_q <= wdata_i[MASK_W-1:0];
  end

  assign mask_o  = mask_q;
  assign rdata_o = {{HI_W{1'b1}}, mask_q};

  // R2
  mask_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> rdata_o[MASK_W-1:0] == $past(wdata_i[MASK_W-1:0]));
  // R10
  mask_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(rdata_o));
  // R3
  mask_upper_ones_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    &rdata_o[ADDR_W-1:MASK_W]);
endmodule

// File: rtl/mag_addr_mask.sv
module mag_addr_mask #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned MASK_W = 16
) (
  input  logic              en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [MASK_W-1:0] mask_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int unsigned HI_W = ADDR_W - MASK_W;

  logic [ADDR_W-1:0] full_mask;

  assign full_mask = {{HI_W{1'b1}}, mask_i};
  assign addr_o    = en_i ? (addr_i & full_mask) : addr_i;
endmodule

// File: rtl/mag_ptr_update.sv
module mag_ptr_update
  import mag_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned MASK_W = 16
) (
  input  logic              en_i,
  input  logic              post_inc_i,
  input  op_size_e          size_i,
  input  logic [ADDR_W-1:0] ea_i,
  input  logic [MASK_W-1:0] mask_i,
  output logic [ADDR_W-1:0] ptr_o
);
  localparam logic [ADDR_W-1:0] INC_WORD = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] INC_LONG = ADDR_W'(4);

  logic [ADDR_W-1:0] inc;
  logic [ADDR_W-1:0] sum;
  logic [ADDR_W-1:0] sum_masked;

  assign inc = (size_i == SZ_LONG) ? INC_LONG : INC_WORD;
  assign sum = ea_i + inc;

  mag_addr_mask #(.ADDR_W(ADDR_W), .MASK_W(MASK_W)) i_wrap (
    .en_i  (en_i),
    .addr_i(sum),
    .mask_i(mask_i),
    .addr_o(sum_masked)
  );

  assign ptr_o = post_inc_i ? sum_masked : ea_i;
endmodule

// File: rtl/mac_addr_gen.sv
module mac_addr_gen
  import mag_pkg::*;
#(
  parameter int unsigned AW = mag_pkg::ADDR_W,
  parameter int unsigned MW = mag_pkg::MASK_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mask_we_i,
  input  logic [AW-1:0] mask_wdata_i,
  output logic [AW-1:0] mask_rdata_o,
  input  logic [AW-1:0] ea_i,
  input  logic          mask_en_i,
  input  logic          mac_move_i,
  input  logic          mask_all_i,
  input  logic          post_inc_i,
  input  logic          size_sel_i,
  output logic [AW-1:0] addr_o,
  output logic [AW-1:0] ptr_next_o
);
  localparam int unsigned HI_W = AW - MW;

  logic [MW-1:0] mask;
  logic          eff_en;
  op_size_e      size;

  assign eff_en = mask_en_i | (mac_move_i & mask_all_i);
  assign size   = op_size_e'(size_sel_i);

  mag_mask_reg #(.ADDR_W(AW), .MASK_W(MW)) i_mask_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (mask_we_i),
    .wdata_i(mask_wdata_i),
    .mask_o (mask),
    .rdata_o(mask_rdata_o)
  );

  mag_addr_mask #(.ADDR_W(AW), .MASK_W(MW)) i_addr_mask (
    .en_i  (eff_en),
    .addr_i(ea_i),
    .mask_i(mask),
    .addr_o(addr_o)
  );

  mag_ptr_update #(.ADDR_W(AW), .MASK_W(MW)) i_ptr_update (
    .en_i      (eff_en),
    .post_inc_i(post_inc_i),
    .size_i    (size),
    .ea_i      (ea_i),
    .mask_i    (mask),
    .ptr_o     (ptr_next_o)
  );

  // R4
  addr_in_region_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_en_i |-> (addr_o & ~mask_rdata_o) == '0);
  // R4
  addr_hi_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_o[AW-1:MW] == ea_i[AW-1:MW]);
  // R5
  addr_passthru_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mask_en_i && !mac_move_i) |-> addr_o == ea_i);
  // R6
  mask_all_move_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mac_move_i && mask_all_i) |-> (addr_o & ~mask_rdata_o) == '0);
  // R7
  ptr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (post_inc_i && !mask_en_i && !mac_move_i) |->
      ptr_next_o - ea_i == (size_sel_i ? AW'(4) : AW'(2)));
  // R8
  ptr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !post_inc_i |-> ptr_next_o == ea_i);
endmodule

// File: tb/test_mac_addr_gen.sv
module test_mac_addr_gen;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        mask_we_i = 1'b0;
  logic [31:0] mask_wdata_i = '0;
  logic [31:0] mask_rdata_o;
  logic [31:0] ea_i = '0;
  logic        mask_en_i = 1'b0;
  logic        mac_move_i = 1'b0;
  logic        mask_all_i = 1'b0;
  logic        post_inc_i = 1'b0;
  logic        size_sel_i = 1'b0;
  logic [31:0] addr_o;
  logic [31:0] ptr_next_o;

  int unsigned n_run = 0;
  int unsigned n_fail = 0;
  logic [15:0] m_mask = 16'hFFFF;
  logic        done = 1'b0;

  always #2 clk_i = ~clk_i;

  mac_addr_gen i_mac_addr_gen (
    .clk_i, .rst_ni, .mask_we_i, .mask_wdata_i, .mask_rdata_o, .ea_i,
    .mask_en_i, .mac_move_i, .mask_all_i, .post_inc_i, .size_sel_i,
    .addr_o, .ptr_next_o
  );

  function automatic logic [31:0] f_mask(logic [31:0] a, logic en, logic [15:0] m);
    return en ? (a & {16'hFFFF, m}) : a;
  endfunction

  function automatic logic [31:0] f_ptr(logic [31:0] a, logic en, logic pi, logic sz,
                                        logic [15:0] m);
    logic [31:0] s;
    s = a + (sz ? 32'd4 : 32'd2);
    return pi ? f_mask(s, en, m) : a;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive at negedge, check comb outputs 1 ns later, model mask update at posedge
  task automatic access(logic [31:0] ea, logic en, logic mv, logic all, logic pi,
                        logic sz, logic we, logic [31:0] wd, string req);
    logic e;
    @(negedge clk_i);
    ea_i = ea; mask_en_i = en; mac_move_i = mv; mask_all_i = all;
    post_inc_i = pi; size_sel_i = sz; mask_we_i = we; mask_wdata_i = wd;
    #1;
    e = en | (mv & all);
    chk({req, " addr"}, addr_o, f_mask(ea, e, m_mask));
    chk({req, " ptr"}, ptr_next_o, f_ptr(ea, e, pi, sz, m_mask));
    chk({req, " rdata"}, mask_rdata_o, {16'hFFFF, m_mask});
    @(posedge clk_i);
    if (we) m_mask = wd[15:0];
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk_i);
    #1;
    chk("R1 reset mask", mask_rdata_o, 32'hFFFF_FFFF);
    @(negedge clk_i);
    rst_ni = 1'b1;
    // R1: reset mask leaves address untouched when enabled
    access(32'hDEAD_BEEF, 1, 0, 0, 0, 0, 0, '0, "R1 R4");
    // R2 R3: upper write data discarded
    access(32'h1234_5678, 0, 0, 0, 0, 0, 1, 32'hABCD_00F0, "R2");
    access(32'h1234_5678, 1, 0, 0, 0, 0, 0, '0, "R2 R3 R4");
    // R10: no write keeps mask
    access(32'h0000_0000, 0, 0, 0, 0, 0, 0, 32'h0000_1111, "R10");
    access(32'hFFFF_FFFF, 1, 0, 0, 0, 0, 0, '0, "R10 R4");
    // R5
    access(32'hCAFE_F00D, 0, 0, 0, 1, 1, 0, '0, "R5 R7");
    // R6: each half of the move term alone has no effect, both together mask
    access(32'hCAFE_F00D, 0, 0, 1, 0, 0, 0, '0, "R6 all only");
    access(32'hCAFE_F00D, 0, 1, 0, 0, 0, 0, '0, "R6 move only");
    access(32'hCAFE_F00D, 0, 1, 1, 0, 0, 0, '0, "R6 both");
    // R9: wrap at top of region, both sizes
    access(32'h0, 0, 0, 0, 0, 0, 1, 32'h0000_00FF, "R9 setup");
    access(32'h2000_00FC, 1, 0, 0, 1, 1, 0, '0, "R9 long");
    chk("R9 long wrap", ptr_next_o, 32'h2000_0000);
    access(32'h2000_00FE, 1, 0, 0, 1, 0, 0, '0, "R9 word");
    chk("R9 word wrap", ptr_next_o, 32'h2000_0000);
    // R8
    access(32'h2000_00FE, 1, 0, 0, 0, 1, 0, '0, "R8");
    // random mix
    for (int i = 0; i < 400; i++) begin
      access($urandom(), 1'($urandom()), 1'($urandom()), 1'($urandom()),
             1'($urandom()), 1'($urandom()), ($urandom() % 4) == 0, $urandom(),
             "R4 R5 R6 R7 R8 R2 rand");
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule